// File: doc/BRIEF.md
# Flash Program and Status-Poll Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. It accepts one request at a time: either program a single word or erase the sector containing a given address. It then plays out the unlock and command write cycles that the flash expects, and waits for the embedded operation to finish by reading status words. The completion decision follows one of two status algorithms, chosen per request. The first compares the polarity of bit 7 with bit 7 of the expected data. The second watches whether bit 6 changes between consecutive reads. Bit 5, the flash's exceeded-time flag, triggers a confirming re-read in both cases.

Once the status says the operation is complete, the block reads the target word once more through a plain array read and compares it with the expected value. An erase is expected to read all ones. If the status reports a failure, or if the programmable iteration limit runs out, the block first writes the read-mode reset command and then reports the error. All flash strobe phases are counted in clock cycles set by parameters, each of which must be at least 1.

The request side is a valid/ready handshake. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from acceptance until the result has been reported, so a waiting request is simply held off. The result is a plain one-cycle pulse with a status code, and it has no back-pressure.

Top module: `flash_pgm_ctrl`

## Requirements
- R1: After reset, chip, output and write enables are high (inactive), the data driver is off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A program request produces exactly these write cycles, in this order. Each write is counted at the rising edge of `fl_we_n`. The cycles are: data 0x00AA at address 0x555, 0x0055 at 0x2AA, 0x00A0 at 0x555, then `req_data` at `req_addr`.
- R3: An erase request produces six write cycles. The first five are 0x00AA@0x555, 0x0055@0x2AA, 0x0080@0x555, 0x00AA@0x555 and 0x0055@0x2AA. The sixth writes 0x0030 to `req_addr`.
- R4: In bit-7 polling (`req_toggle`=0), each poll reads `req_addr`. The operation is complete when bit 7 of the read equals bit 7 of the expected word (that word is `req_data`, or all ones for erase). While bit 7 differs and bit 5 is 0, polling continues.
- R5: In bit-7 polling, a read whose bit 7 differs but whose bit 5 is 1 causes exactly one more read. The operation is complete if that read's bit 7 matches. Otherwise the result is status 1 (device failure).
- R6: In bit-6 polling (`req_toggle`=1), each poll makes two reads. Equal bit 6 in both reads means complete. Differing bit 6 with bit 5 = 0 in the second read means polling continues.
- R7: In bit-6 polling, differing bit 6 with bit 5 = 1 in the second read causes two more reads. The operation is complete if bit 6 is equal in those two reads; otherwise the result is status 1.
- R8: `fl_we_n` and `fl_oe_n` are never low together. The data driver is on only while `fl_oe_n` is high. Between any two read strobes, `fl_ce_n` and `fl_oe_n` both return high.
- R9: After completion, one more read of `req_addr` is made. The status is 0 if it equals the expected word, and 3 (verify mismatch) otherwise.
- R10: On status 1 or 2, a write of 0x00F0 to address 0 is issued before the response. It is not issued for status 0 or 3.
- R11: If `POLL_LIMIT` poll iterations pass without completion, the result is status 2 (timeout). Confirming re-reads do not count as iterations.
- R12: `req_ready` falls on the cycle after acceptance and stays low until the response. `rsp_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_erase | input | 1 | 1 = sector erase, 0 = word program |
| req_toggle | input | 1 | 1 = bit-6 polling, 0 = bit-7 polling |
| req_addr | input | AW | Target word address (any word of the sector for erase) |
| req_data | input | DW | Word to program |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_status | output | 2 | 0 ok, 1 device failure, 2 timeout, 3 verify mismatch |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Data driven to the flash |
| fl_dq_oe | output | 1 | Enable for the data driver |
| fl_dq_in | input | DW | Data read from the flash |

## Verification
A wrong command step or address shows up as a wrong write cycle at the rising edge of `fl_we_n`. The write log seen by the flash model catches it in the same request. A misjudged poll verdict changes the number of reads, and so the status code reported at the end of that request. It can also add or remove the reset write. A wrong iteration count only becomes visible when a flash that never finishes yields anything but status 2. The flash model in the bench is scripted per request, setting how many busy reads it returns, when bit 5 appears and which bits stay stuck. Every completion branch and failure branch is therefore reached on purpose, and also reached again by random mixes.

// File: rtl/flash_pctl_pkg.sv
package flash_pctl_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_DEVFAIL = 2'd1,
    ST_TIMEOUT = 2'd2,
    ST_VERIFY  = 2'd3
  } fstat_e;

  typedef enum logic [1:0] {
    PV_DONE,
    PV_AGAIN,
    PV_RECHECK,
    PV_FAIL
  } verdict_e;

  typedef enum logic [1:0] {
    BP_IDLE,
    BP_SETUP,
    BP_ACT,
    BP_GAP
  } bphase_e;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_CMD,
    CS_ITER,
    CS_RD_A,
    CS_RD_B,
    CS_VERIFY,
    CS_RESET,
    CS_RESP
  } ctl_e;

  localparam logic [11:0] UNLOCK_HI = 12'h555;
  localparam logic [11:0] UNLOCK_LO = 12'h2AA;

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_pctl_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int READ_CYC  = 2,
  parameter int GAP_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);
  localparam int M1   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2   = (READ_CYC > GAP_CYC) ? READ_CYC : GAP_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  bphase_e       ph;
  logic [CW-1:0] cnt;
  logic          lat_wr;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= BP_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      rdata    <= '0;
      lat_wr   <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      done <= 1'b0;
      case (ph)
        BP_IDLE: if (start) begin
          lat_wr   <= wr;
          lat_addr <= addr;
          lat_data <= wdata;
          cnt      <= CW'(SETUP_CYC - 1);
          ph       <= BP_SETUP;
        end
        BP_SETUP: if (cnt == '0) begin
          cnt <= lat_wr ? CW'(PULSE_CYC - 1) : CW'(READ_CYC - 1);
          ph  <= BP_ACT;
        end else cnt <= cnt - 1'b1;
        BP_ACT: if (cnt == '0) begin
          if (!lat_wr) rdata <= dq_in;
          cnt <= CW'(GAP_CYC - 1);
          ph  <= BP_GAP;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          ph   <= BP_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign ce_n     = !(ph == BP_SETUP || ph == BP_ACT);
  assign oe_n     = !(ph == BP_ACT && !lat_wr);
  assign we_n     = !(ph == BP_ACT && lat_wr);
  assign dq_oe    = lat_wr && (ph != BP_IDLE);
  assign bus_addr = lat_addr;
  assign dq_out   = lat_data;

endmodule

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_pctl_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          erase,
  input  logic [2:0]    step,
  input  logic [AW-1:0] target,
  input  logic [DW-1:0] data,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          last
);
  always_comb begin
    waddr = AW'(UNLOCK_HI);
    wdata = DW'(8'hAA);
    last  = 1'b0;
    if (!erase) begin
      case (step)
        3'd0: begin waddr = AW'(UNLOCK_HI); wdata = DW'(8'hAA); end
        3'd1: begin waddr = AW'(UNLOCK_LO); wdata = DW'(8'h55); end
        3'd2: begin waddr = AW'(UNLOCK_HI); wdata = DW'(8'hA0); end
        default: begin waddr = target; wdata = data; last = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0, 3'd3: begin waddr = AW'(UNLOCK_HI); wdata = DW'(8'hAA); end
        3'd1, 3'd4: begin waddr = AW'(UNLOCK_LO); wdata = DW'(8'h55); end
        3'd2:       begin waddr = AW'(UNLOCK_HI); wdata = DW'(8'h80); end
        default:    begin waddr = target; wdata = DW'(8'h30); last = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
  import flash_pctl_pkg::*;
(
  input  logic     toggle,
  input  logic     recheck,
  input  logic     prev_b6,
  input  logic     cur_b7,
  input  logic     cur_b6,
  input  logic     cur_b5,
  input  logic     exp_b7,
  output verdict_e verdict
);
  logic settled;

  always_comb begin
    settled = toggle ? (prev_b6 == cur_b6) : (cur_b7 == exp_b7);
    if (settled)      verdict = PV_DONE;
    else if (recheck) verdict = PV_FAIL;
    else if (cur_b5)  verdict = PV_RECHECK;
    else              verdict = PV_AGAIN;
  end
endmodule

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl
  import flash_pctl_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int READ_CYC   = 2,
  parameter int GAP_CYC    = 1,
  parameter int POLL_LIMIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_erase,
  input  logic          req_toggle,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in
);
  localparam int IW = $clog2(POLL_LIMIT + 1);

  ctl_e          st;
  logic          op_erase, op_toggle;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [2:0]    step;
  logic [IW-1:0] iter;
  logic          recheck;
  logic          prev_b6;
  logic          wait_bus;
  fstat_e        status;

  logic          bus_start, bus_wr, bus_done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_data;
  logic          rom_last;
  verdict_e      verdict;
  logic [DW-1:0] exp_word;

  logic          l_use, l_wr;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_data;

  assign exp_word = op_erase ? '1 : op_data;

  flash_cmd_rom #(.AW(AW), .DW(DW)) rom_i (
    .erase(op_erase), .step(step), .target(op_addr), .data(op_data),
    .waddr(rom_addr), .wdata(rom_data), .last(rom_last)
  );

  flash_poll_judge judge_i (
    .toggle(op_toggle), .recheck(recheck), .prev_b6(prev_b6),
    .cur_b7(bus_rdata[7]), .cur_b6(bus_rdata[6]), .cur_b5(bus_rdata[5]),
    .exp_b7(exp_word[7]), .verdict(verdict)
  );

  flash_bus_cycle #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .READ_CYC(READ_CYC), .GAP_CYC(GAP_CYC)
  ) bus_i (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .done(bus_done), .rdata(bus_rdata),
    .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n), .bus_addr(fl_addr),
    .dq_out(fl_dq_out), .dq_oe(fl_dq_oe), .dq_in(fl_dq_in)
  );

  // Cycle to launch in the current state
  always_comb begin
    l_use  = 1'b1;
    l_wr   = 1'b0;
    l_addr = op_addr;
    l_data = '0;
    case (st)
      CS_CMD:   begin l_wr = 1'b1; l_addr = rom_addr; l_data = rom_data; end
      CS_RESET: begin l_wr = 1'b1; l_addr = '0; l_data = DW'(8'hF0); end
      CS_RD_A, CS_RD_B, CS_VERIFY: l_wr = 1'b0;
      default:  l_use = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= CS_IDLE;
      op_erase  <= 1'b0;
      op_toggle <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      step      <= '0;
      iter      <= '0;
      recheck   <= 1'b0;
      prev_b6   <= 1'b0;
      wait_bus  <= 1'b0;
      status    <= ST_OK;
      bus_start <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_start <= 1'b0;
      if (l_use && !wait_bus) begin
        bus_start <= 1'b1;
        bus_wr    <= l_wr;
        bus_addr  <= l_addr;
        bus_wdata <= l_data;
        wait_bus  <= 1'b1;
      end
      case (st)
        CS_IDLE: if (req_valid) begin
          op_erase  <= req_erase;
          op_toggle <= req_toggle;
          op_addr   <= req_addr;
          op_data   <= req_data;
          step      <= '0;
          iter      <= '0;
          status    <= ST_OK;
          st        <= CS_CMD;
        end
        CS_CMD: if (wait_bus && bus_done) begin
          wait_bus <= 1'b0;
          if (rom_last) st <= CS_ITER;
          else          step <= step + 1'b1;
        end
        CS_ITER: begin
          recheck <= 1'b0;
          if (iter == IW'(POLL_LIMIT)) begin
            status <= ST_TIMEOUT;
            st     <= CS_RESET;
          end else begin
            iter <= iter + 1'b1;
            st   <= op_toggle ? CS_RD_A : CS_RD_B;
          end
        end
        CS_RD_A: if (wait_bus && bus_done) begin
          wait_bus <= 1'b0;
          prev_b6  <= bus_rdata[6];
          st       <= CS_RD_B;
        end
        CS_RD_B: if (wait_bus && bus_done) begin
          wait_bus <= 1'b0;
          case (verdict)
            PV_DONE:    st <= CS_VERIFY;
            PV_AGAIN:   st <= CS_ITER;
            PV_RECHECK: begin
              recheck <= 1'b1;
              st      <= op_toggle ? CS_RD_A : CS_RD_B;
            end
            default: begin
              status <= ST_DEVFAIL;
              st     <= CS_RESET;
            end
          endcase
        end
        CS_VERIFY: if (wait_bus && bus_done) begin
          wait_bus <= 1'b0;
          status   <= (bus_rdata == exp_word) ? ST_OK : ST_VERIFY;
          st       <= CS_RESP;
        end
        CS_RESET: if (wait_bus && bus_done) begin
          wait_bus <= 1'b0;
          st       <= CS_RESP;
        end
        default: st <= CS_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == CS_IDLE);
  assign rsp_valid  = (st == CS_RESP);
  assign rsp_status = status;

endmodule

// File: rtl/flash_pctl_chk.sv
module flash_pctl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic fl_ce_n,
  input logic fl_oe_n,
  input logic fl_we_n,
  input logic fl_dq_oe
);
  // R8
  no_strobe_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  // R8
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_dq_oe |-> fl_oe_n);

  // R8
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_oe_n) |=> (fl_oe_n && fl_ce_n));

  // R2
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n);

  // R12
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R12
  rsp_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind flash_pgm_ctrl flash_pctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
  .fl_we_n(fl_we_n), .fl_dq_oe(fl_dq_oe)
);

// File: tb/flash_pgm_ctrl_tb.sv
module flash_pgm_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_erase = 1'b0, req_toggle = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        req_ready, rsp_valid;
  logic [1:0]  rsp_status;
  logic        fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [19:0] fl_addr;
  logic [15:0] fl_dq_out, fl_dq_in;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  flash_pgm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_toggle(req_toggle), .req_addr(req_addr),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in)
  );

  // Scripted flash model
  int          n_busy = 0, q5m = 0, rd_idx = 0, wr_cnt = 0, arm_at = 4;
  logic        armed = 1'b0, tgt7 = 1'b0;
  logic [15:0] stored = '0;
  logic [19:0] wlog_a [0:15];
  logic [15:0] wlog_d [0:15];

  function automatic logic [15:0] model_word(logic arm, int idx, int nb, int q,
                                             logic [15:0] st, logic t7);
    logic busy, f5;
    busy = (q == 2) ? 1'b1 : (idx < nb + ((q == 1) ? 1 : 0));
    f5   = (q != 0) && (idx >= nb);
    if (arm && busy) return {8'h00, ~t7, idx[0], f5, 5'b0};
    return st;
  endfunction

  assign fl_dq_in = model_word(armed, rd_idx, n_busy, q5m, stored, tgt7);

  always @(posedge fl_we_n) begin
    if (wr_cnt < 16) begin
      wlog_a[wr_cnt] = fl_addr;
      wlog_d[wr_cnt] = fl_dq_out;
    end
    wr_cnt = wr_cnt + 1;
    if (wr_cnt == arm_at) begin armed = 1'b1; rd_idx = 0; end
    if (fl_dq_out == 16'h00F0) armed = 1'b0;
  end

  always @(posedge fl_oe_n) rd_idx = rd_idx + 1;

  // Bus rule monitor (R8)
  int bus_viol = 0, reads_seen = 0;
  logic ce_high_seen = 1'b1;
  always @(posedge clk) if (rst_n && !fl_we_n && !fl_oe_n) bus_viol++;
  always @(posedge fl_ce_n) ce_high_seen = 1'b1;
  always @(negedge fl_oe_n) begin
    if (reads_seen > 0 && !ce_high_seen) bus_viol++;
    ce_high_seen = 1'b0;
    reads_seen++;
  end

  task automatic chk(bit ok, string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_wr(bit er, int i, logic [19:0] a, logic [15:0] d);
    if (!er) begin
      case (i)
        0: return {20'h555, 16'h00AA};
        1: return {20'h2AA, 16'h0055};
        2: return {20'h555, 16'h00A0};
        3: return {a, d};
        default: return {20'h0, 16'h00F0};
      endcase
    end
    case (i)
      0, 3: return {20'h555, 16'h00AA};
      1, 4: return {20'h2AA, 16'h0055};
      2: return {20'h555, 16'h0080};
      5: return {a, 16'h0030};
      default: return {20'h0, 16'h00F0};
    endcase
  endfunction

  function automatic int exp_status(bit er, logic [15:0] d, int nb, int q, logic [15:0] msk);
    logic [15:0] t;
    t = er ? 16'hFFFF : d;
    if (q == 2) return 1;
    if (nb >= 1000) return 2;
    if ((t & msk) != t) return 3;
    return 0;
  endfunction

  task automatic run_op(bit er, bit tg, logic [19:0] a, logic [15:0] d,
                        int nb, int q, logic [15:0] msk, string tag);
    logic [15:0] t;
    int es, nw, guard, bad;
    logic [1:0] got;
    t = er ? 16'hFFFF : d;
    @(negedge clk);
    arm_at = er ? 6 : 4; tgt7 = t[7]; stored = t & msk;
    wr_cnt = 0; rd_idx = 0; armed = 1'b0; n_busy = nb; q5m = q;
    chk(req_ready == 1'b1, {tag, " R12 ready idle"}, 40'(req_ready), 40'd1);
    req_valid = 1'b1; req_erase = er; req_toggle = tg; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, " R12 ready low"}, 40'(req_ready), 40'd0);
    guard = 0;
    while (!rsp_valid && guard < 20000) begin @(negedge clk); guard++; end
    got = rsp_status;
    es = exp_status(er, d, nb, q, msk);
    chk(got == 2'(es), {tag, " R4 R5 R6 R7 R9 R11 status"}, 40'(got), 40'(es));
    @(negedge clk);
    chk(rsp_valid == 1'b0, {tag, " R12 one-cycle rsp"}, 40'(rsp_valid), 40'd0);
    nw = (er ? 6 : 4) + ((es == 1 || es == 2) ? 1 : 0);
    chk(wr_cnt == nw, {tag, " R2 R3 R10 write count"}, 40'(wr_cnt), 40'(nw));
    bad = 0;
    for (int i = 0; i < nw && i < 16; i++)
      if ({wlog_a[i], wlog_d[i]} != exp_wr(er, i, a, d)) begin
        bad++;
        chk(1'b0, {tag, " R2 R3 R10 write cycle"}, 40'({wlog_a[i], wlog_d[i]}),
            40'(exp_wr(er, i, a, d)));
      end
    if (bad == 0) chk(1'b1, {tag, " R2 R3 R10 writes"}, 40'd0, 40'd0);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state while reset is held
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1 bus idle", 40'({fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}), 40'b1110);
    chk(req_ready && !rsp_valid, "R1 handshake idle", 40'({req_ready, rsp_valid}), 40'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(0, 0, 20'h01234, 16'h5A3C, 3, 0, 16'hFFFF, "R2 R4 prog bit7");
    run_op(0, 0, 20'h00010, 16'h0080, 0, 0, 16'hFFFF, "R4 immediate");
    run_op(1, 1, 20'h48000, 16'h0000, 4, 0, 16'hFFFF, "R3 R6 erase toggle");
    run_op(1, 0, 20'h7FFFF, 16'h0000, 2, 0, 16'hFFFF, "R3 R4 erase bit7");
    run_op(0, 0, 20'h00200, 16'h1234, 2, 1, 16'hFFFF, "R5 recheck pass");
    run_op(0, 0, 20'h00300, 16'hABCD, 1, 2, 16'hFFFF, "R5 R10 recheck fail");
    run_op(1, 1, 20'h10000, 16'h0000, 3, 1, 16'hFFFF, "R7 toggle recheck pass");
    run_op(0, 1, 20'h00400, 16'h00FF, 2, 2, 16'hFFFF, "R7 R10 toggle fail");
    run_op(0, 1, 20'h00500, 16'h4444, 0, 0, 16'hFFFF, "R6 already done");
    run_op(0, 0, 20'h00600, 16'hFFFF, 1000, 0, 16'hFFFF, "R11 R10 timeout bit7");
    run_op(1, 1, 20'h20000, 16'h0000, 1000, 0, 16'hFFFF, "R11 timeout toggle");
    run_op(0, 0, 20'h00700, 16'h0001, 1, 0, 16'hFFFE, "R9 verify mismatch");
    run_op(1, 1, 20'h30000, 16'h0000, 2, 0, 16'hEFFF, "R9 erase stuck bit");

    for (int n = 0; n < 40; n++) begin
      logic [15:0] msk;
      int pick, q;
      pick = int'($urandom % 15);
      if (pick >= 7) pick++;
      msk = (($urandom % 4) == 0) ? ~(16'h0001 << pick) : 16'hFFFF;
      q = (($urandom % 2) == 0) ? 0 : int'($urandom % 3);
      run_op(1'($urandom), 1'($urandom), 20'($urandom), 16'($urandom),
             int'($urandom % 7), q, msk, "rand R4 R6");
    end

    chk(bus_viol == 0, "R8 strobe and read-gap rules", 40'(bus_viol), 40'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule